// File: doc/BRIEF.md
# Programmable CRC-32 Register Peripheral

A memory-mapped checksum engine on a simple 32-bit register bus with byte strobes. Software sets a 32-bit starting value and a 32-bit generator polynomial, pulses a reload bit to copy the starting value into the running checksum, then writes the message to the data register. Each data write is folded into the checksum in the same cycle, either as one byte or as a whole 32-bit word, depending on which byte strobes are active. Unaligned message heads and tails can therefore be fed as single bytes, and the aligned middle as words.

The written data can be bit-reversed before it is folded: across the whole word, within each byte, or not at all. The value returned by a data-register read can be bit-reversed separately. Together with a reflected bit order on both sides, this lets the engine produce the usual reflected CRC-32 variants. Reading the data register straight after a reload returns the starting value. A partial checksum can therefore be read out, parked, and later restored through the starting-value register. The input mode can be changed between data writes without disturbing the running value.

Top module: `progcrc_top`

## Requirements
- R1: After synchronous reset the starting-value register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0, and the running checksum equals 0xFFFFFFFF.
- R2: Registers sit at word-aligned byte offsets: data 0x00, control 0x08, starting value 0x10, polynomial 0x14. Address bits 1:0 are ignored. Writes to the starting-value and polynomial registers update only the byte lanes whose strobe is set (strobe bit k covers bits 8k+7:8k).
- R3: Writing control bit 0 as 1 (with strobe 0 set) copies the starting-value register into the running checksum in that cycle. A data read on the next cycle returns that value.
- R4: A data write with all four strobes set folds 32 bits, most significant bit first, into the checksum. Each step shifts left by one and XORs the polynomial when the outgoing bit 31 differs from the data bit (implicit x^32 term). Byte lane 0 is bits 7:0.
- R5: A data write with exactly one strobe set folds the 8 bits of that lane, bit 7 first.
- R6: Control bits 6:5 select input reversal. For word writes, 2'b11 mirrors the whole word (bit 31 with bit 0), 2'b01 mirrors each byte in place, and 2'b00 or 2'b10 leaves the data as is. For byte writes, 2'b01 or 2'b11 mirror the byte and the other codes leave it unchanged.
- R7: Control bit 7 set makes data reads return the bit-mirrored checksum (bit 31 with bit 0). The stored checksum is not altered.
- R8: Rewriting the control register without bit 0 set changes the input and output modes for later accesses and keeps the running checksum.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets, and data writes whose strobe pattern has zero, two or three bits set, change no register and no checksum.
- R10: A control read returns bits 7:5 as last written and 0 in all other bits, including bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes for writes |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access, 0 otherwise |

## Verification
The folding function is tried three ways. First, with words and with single bytes in every lane, under two different polynomials: this separates lane selection and bit ordering from the polynomial taps. Second, under each of the four input-reversal codes, so that word mirroring, per-byte mirroring and the pass-through codes each give their own result. Third, with a mixed word-then-byte message of nine ASCII digits under reflected settings. That message must give the known reflected CRC-32 residue 0x340BC6D9, which ties mode switching and output mirroring to an outside reference. Ignored strobe patterns and unmapped accesses are followed by a data read, so that any stray update shows up.

// File: rtl/progcrc_pkg.sv
package progcrc_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;

    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_INIT = 8'h10;
    localparam logic [7:0] OFS_POLY = 8'h14;

    // Input reversal code, control bits 6:5
    typedef enum logic [1:0] {
        REV_NONE = 2'b00,
        REV_BYTE = 2'b01,
        REV_RSVD = 2'b10,
        REV_WORD = 2'b11
    } rev_mode_e;

    typedef struct packed {
        logic      out_rev;   // bit 7
        rev_mode_e in_rev;    // bits 6:5
    } ctrl_t;

    typedef enum logic [1:0] {
        FEED_NONE = 2'b00,
        FEED_BYTE = 2'b01,
        FEED_WORD = 2'b10
    } feed_kind_e;

    typedef struct packed {
        feed_kind_e         kind;
        logic [WORD_W-1:0]  data;   // byte feeds use data[7:0]
    } feed_t;

    // One step of MSB-first division with implicit x^32
    function automatic logic [WORD_W-1:0] crc_step(
        input logic [WORD_W-1:0] c,
        input logic [WORD_W-1:0] p,
        input logic              b
    );
        return {c[WORD_W-2:0], 1'b0} ^ ((c[WORD_W-1] ^ b) ? p : '0);
    endfunction

    function automatic logic [7:0] mirror8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // Byte-lane write merge
    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] new_v,
        input logic [LANES-1:0]  be
    );
        logic [WORD_W-1:0] r;
        r = old_v;
        for (int l = 0; l < LANES; l++)
            if (be[l]) r[l*8 +: 8] = new_v[l*8 +: 8];
        return r;
    endfunction

endpackage

// File: rtl/progcrc_regs.sv
module progcrc_regs
    import progcrc_pkg::*;
#(
    parameter int unsigned     ADDR_W   = 8,
    parameter logic [31:0]     INIT_RST = 32'hFFFF_FFFF,
    parameter logic [31:0]     POLY_RST = 32'h04C1_1DB7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic [LANES-1:0]   bus_be,
    output ctrl_t              ctrl_q,
    output logic [WORD_W-1:0]  init_q,
    output logic [WORD_W-1:0]  poly_q,
    output logic               reload,
    output feed_t              feed
);

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] IX_DATA = IDX_W'(OFS_DATA >> 2);
    localparam logic [IDX_W-1:0] IX_CTRL = IDX_W'(OFS_CTRL >> 2);
    localparam logic [IDX_W-1:0] IX_INIT = IDX_W'(OFS_INIT >> 2);
    localparam logic [IDX_W-1:0] IX_POLY = IDX_W'(OFS_POLY >> 2);

    logic [IDX_W-1:0] idx;
    logic             wr;
    logic             wr_data, wr_ctrl, wr_init, wr_poly;
    logic [7:0]       lane_byte;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign wr      = bus_sel && bus_we;
    assign wr_data = wr && (idx == IX_DATA);
    assign wr_ctrl = wr && (idx == IX_CTRL);
    assign wr_init = wr && (idx == IX_INIT);
    assign wr_poly = wr && (idx == IX_POLY);

    assign reload  = wr_ctrl && bus_be[0] && bus_wdata[0];

    always_comb begin
        lane_byte = '0;
        for (int l = 0; l < LANES; l++)
            if (bus_be[l]) lane_byte = bus_wdata[l*8 +: 8];
    end

    always_comb begin
        feed.kind = FEED_NONE;
        feed.data = bus_wdata;
        if (wr_data) begin
            if (&bus_be) begin
                feed.kind = FEED_WORD;
            end else if ($countones(bus_be) == 1) begin
                feed.kind = FEED_BYTE;
                feed.data = {{(WORD_W-8){1'b0}}, lane_byte};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{out_rev: 1'b0, in_rev: REV_NONE};
            init_q <= INIT_RST;
            poly_q <= POLY_RST;
        end else begin
            if (wr_ctrl && bus_be[0]) begin
                ctrl_q.out_rev <= bus_wdata[7];
                ctrl_q.in_rev  <= rev_mode_e'(bus_wdata[6:5]);
            end
            if (wr_init) init_q <= lane_merge(init_q, bus_wdata, bus_be);
            if (wr_poly) poly_q <= lane_merge(poly_q, bus_wdata, bus_be);
        end
    end

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (init_q == INIT_RST && poly_q == POLY_RST)); // R1

    AST_FEED_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (rst)
        (feed.kind != FEED_NONE) |-> (bus_sel && bus_we && !reload)); // R9

endmodule

// File: rtl/progcrc_core.sv
module progcrc_core
    import progcrc_pkg::*;
#(
    parameter logic [31:0] INIT_RST = 32'hFFFF_FFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  rev_mode_e          in_rev,
    input  logic [WORD_W-1:0]  poly,
    input  logic [WORD_W-1:0]  init_val,
    input  logic               reload,
    input  feed_t              feed,
    output logic [WORD_W-1:0]  crc_q
);

    logic [WORD_W-1:0] word_mir, byte_mir, word_in;
    logic [7:0]        byte_in;
    logic [WORD_W-1:0] after_word, after_byte;

    // Whole-word mirror and per-lane mirror
    for (genvar i = 0; i < WORD_W; i++) begin : g_wmir
        assign word_mir[i] = feed.data[WORD_W-1-i];
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar b = 0; b < 8; b++) begin : g_bit
            assign byte_mir[l*8+b] = feed.data[l*8+7-b];
        end
    end

    always_comb begin
        unique case (in_rev)
            REV_WORD: word_in = word_mir;
            REV_BYTE: word_in = byte_mir;
            default:  word_in = feed.data;
        endcase
        byte_in = (in_rev == REV_WORD || in_rev == REV_BYTE)
                ? mirror8(feed.data[7:0]) : feed.data[7:0];
    end

    always_comb begin
        after_word = crc_q;
        for (int i = WORD_W-1; i >= 0; i--)
            after_word = crc_step(after_word, poly, word_in[i]);
    end

    always_comb begin
        after_byte = crc_q;
        for (int i = 7; i >= 0; i--)
            after_byte = crc_step(after_byte, poly, byte_in[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= INIT_RST;
        end else if (reload) begin
            crc_q <= init_val;
        end else begin
            unique case (feed.kind)
                FEED_WORD: crc_q <= after_word;
                FEED_BYTE: crc_q <= after_byte;
                default:   crc_q <= crc_q;
            endcase
        end
    end

    AST_RELOAD_LOADS_INIT: assert property (@(posedge clk) disable iff (rst)
        reload |=> (crc_q == $past(init_val))); // R3

    AST_IDLE_HOLDS_CRC: assert property (@(posedge clk) disable iff (rst)
        (!reload && feed.kind == FEED_NONE) |=> $stable(crc_q)); // R9

endmodule

// File: rtl/progcrc_top.sv
module progcrc_top
    import progcrc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [31:0] INIT_RST = 32'hFFFF_FFFF,
    parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    ctrl_t             ctrl_q;
    logic [WORD_W-1:0] init_q, poly_q, crc_q, crc_mir, crc_view;
    logic              reload;
    feed_t             feed;
    logic [IDX_W-1:0]  idx;
    logic              rd;

    progcrc_regs #(
        .ADDR_W  (ADDR_W),
        .INIT_RST(INIT_RST),
        .POLY_RST(POLY_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_be   (bus_be),
        .ctrl_q   (ctrl_q),
        .init_q   (init_q),
        .poly_q   (poly_q),
        .reload   (reload),
        .feed     (feed)
    );

    progcrc_core #(
        .INIT_RST(INIT_RST)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .in_rev  (ctrl_q.in_rev),
        .poly    (poly_q),
        .init_val(init_q),
        .reload  (reload),
        .feed    (feed),
        .crc_q   (crc_q)
    );

    for (genvar i = 0; i < WORD_W; i++) begin : g_omir
        assign crc_mir[i] = crc_q[WORD_W-1-i];
    end
    assign crc_view = ctrl_q.out_rev ? crc_mir : crc_q;

    assign idx = bus_addr[ADDR_W-1:2];
    assign rd  = bus_sel && !bus_we;

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (idx)
                IDX_W'(OFS_DATA >> 2): bus_rdata = crc_view;
                IDX_W'(OFS_CTRL >> 2): bus_rdata = {24'h0, ctrl_q.out_rev,
                                                    ctrl_q.in_rev, 5'b0};
                IDX_W'(OFS_INIT >> 2): bus_rdata = init_q;
                IDX_W'(OFS_POLY >> 2): bus_rdata = poly_q;
                default:               bus_rdata = '0;
            endcase
        end
    end

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && idx != IDX_W'(OFS_DATA >> 2) && idx != IDX_W'(OFS_CTRL >> 2) &&
         idx != IDX_W'(OFS_INIT >> 2) && idx != IDX_W'(OFS_POLY >> 2))
        |-> (bus_rdata == '0)); // R9

    AST_CTRL_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && idx == IDX_W'(OFS_CTRL >> 2)) |-> (bus_rdata[4:0] == 5'b0)); // R10

    AST_NO_READ_SIDE_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (rd && !reload) |=> $stable(crc_q)); // R7

endmodule

// File: tb/progcrc_top_test.sv
`timescale 1ns/1ps
module progcrc_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    progcrc_top uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata)
    );

    localparam logic [7:0] A_DATA = 8'h00, A_CTRL = 8'h08,
                           A_INIT = 8'h10, A_POLY = 8'h14;
    localparam logic [31:0] P_STD = 32'h04C11DB7, P_CAS = 32'h1EDC6F41;

    // ---------------- reference model ----------------
    function automatic logic [31:0] m_fold(input logic [31:0] c,
        input logic [31:0] p, input logic [31:0] d, input int n);
        for (int i = n-1; i >= 0; i--) begin
            logic fb;
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ p;
        end
        return c;
    endfunction

    function automatic logic [31:0] m_rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [7:0] m_rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [31:0] m_revlanes(input logic [31:0] v);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = m_rev8(v[l*8 +: 8]);
        return r;
    endfunction

    // ---------------- bus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk);
        #1 bus_sel = 0; bus_we = 0; bus_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 0;
    endtask

    task automatic check(input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic start(input logic [31:0] init, input logic [31:0] poly,
                         input logic [7:0] ctrl);
        wr(A_INIT, init, 4'hF);
        wr(A_POLY, poly, 4'hF);
        wr(A_CTRL, {24'h0, ctrl | 8'h01}, 4'h1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        logic [31:0] v;
        rd(A_INIT, v); check("R1 init reset", v, 32'hFFFFFFFF);
        rd(A_POLY, v); check("R1 poly reset", v, P_STD);
        rd(A_CTRL, v); check("R1 ctrl reset", v, 32'h0);
        rd(A_DATA, v); check("R1 crc reset", v, 32'hFFFFFFFF);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(A_INIT, 32'h12345678, 4'hF);
        rd(A_INIT, v); check("R2 init full write", v, 32'h12345678);
        wr(A_POLY, 32'hEEEEABEE, 4'b0010);
        rd(A_POLY, v); check("R2 poly lane1 write", v, 32'h04C1ABB7);
        wr(A_POLY, P_STD, 4'hF);
        wr(A_INIT + 8'h2, 32'hFF000000, 4'b1000);
        rd(A_INIT, v); check("R2 init lane3, addr low bits ignored", v, 32'hFF345678);
    endtask

    task automatic t_reload;
        logic [31:0] v;
        wr(A_INIT, 32'hCAFEF00D, 4'hF);
        wr(A_CTRL, 32'h0000_0061, 4'h1);
        rd(A_DATA, v); check("R3 data after reload", v, 32'hCAFEF00D);
        rd(A_CTRL, v); check("R10 ctrl readback bit0 low", v, 32'h60);
    endtask

    task automatic t_word;
        logic [31:0] v, e;
        start(32'hFFFFFFFF, P_STD, 8'h00);
        wr(A_DATA, 32'hDEADBEEF, 4'hF);
        wr(A_DATA, 32'h00000001, 4'hF);
        e = m_fold(m_fold(32'hFFFFFFFF, P_STD, 32'hDEADBEEF, 32), P_STD, 32'h1, 32);
        rd(A_DATA, v); check("R4 two words std poly", v, e);
        start(32'h00000000, P_CAS, 8'h00);
        wr(A_DATA, 32'h80000000, 4'hF);
        e = m_fold(32'h0, P_CAS, 32'h80000000, 32);
        rd(A_DATA, v); check("R4 word alt poly", v, e);
    endtask

    task automatic t_byte;
        logic [31:0] v, e;
        start(32'h89ABCDEF, P_STD, 8'h00);
        e = 32'h89ABCDEF;
        for (int l = 0; l < 4; l++) begin
            logic [31:0] d;
            d = 32'hA1B2C3D4;
            wr(A_DATA, d, 4'b0001 << l);
            e = m_fold(e, P_STD, {24'h0, d[l*8 +: 8]}, 8);
        end
        rd(A_DATA, v); check("R5 byte per lane", v, e);
    endtask

    task automatic t_modes;
        logic [31:0] v;
        logic [31:0] d;
        d = 32'h0123A5F0;
        start(32'h5A5A5A5A, P_STD, 8'h60);
        wr(A_DATA, d, 4'hF);
        rd(A_DATA, v); check("R6 word mirror 11", v, m_fold(32'h5A5A5A5A, P_STD, m_rev32(d), 32));
        start(32'h5A5A5A5A, P_STD, 8'h20);
        wr(A_DATA, d, 4'hF);
        rd(A_DATA, v); check("R6 lane mirror 01", v, m_fold(32'h5A5A5A5A, P_STD, m_revlanes(d), 32));
        start(32'h5A5A5A5A, P_STD, 8'h40);
        wr(A_DATA, d, 4'hF);
        rd(A_DATA, v); check("R6 code 10 pass", v, m_fold(32'h5A5A5A5A, P_STD, d, 32));
        start(32'h5A5A5A5A, P_STD, 8'h60);
        wr(A_DATA, 32'h00000013, 4'b0001);
        rd(A_DATA, v); check("R6 byte mirror 11", v, m_fold(32'h5A5A5A5A, P_STD, {24'h0, m_rev8(8'h13)}, 8));
    endtask

    task automatic t_outrev;
        logic [31:0] v, e;
        start(32'h0000F00F, P_STD, 8'h80);
        wr(A_DATA, 32'h11223344, 4'hF);
        e = m_fold(32'h0000F00F, P_STD, 32'h11223344, 32);
        rd(A_DATA, v); check("R7 mirrored read", v, m_rev32(e));
        wr(A_CTRL, 32'h0, 4'h1);
        rd(A_DATA, v); check("R7 state unchanged", v, e);
    endtask

    task automatic t_vector;
        logic [31:0] v;
        start(32'hFFFFFFFF, P_STD, 8'hE0);
        wr(A_DATA, 32'h34333231, 4'hF);
        wr(A_DATA, 32'h38373635, 4'hF);
        wr(A_CTRL, 32'h000000A0, 4'h1);
        wr(A_DATA, 32'h00000039, 4'b0001);
        rd(A_DATA, v); check("R8 mode switch reflected residue", v, 32'h340BC6D9);
    endtask

    task automatic t_ignore;
        logic [31:0] v, e;
        start(32'h13579BDF, P_STD, 8'h00);
        e = 32'h13579BDF;
        wr(8'h04, 32'hFFFFFFFF, 4'hF);
        wr(8'h0C, 32'hFFFFFFFF, 4'hF);
        wr(8'h18, 32'hFFFFFFFF, 4'hF);
        wr(A_DATA, 32'hFFFFFFFF, 4'b0011);
        wr(A_DATA, 32'hFFFFFFFF, 4'b0111);
        wr(A_DATA, 32'hFFFFFFFF, 4'b0000);
        rd(A_DATA, v); check("R9 crc untouched", v, e);
        rd(A_INIT, v); check("R9 init untouched", v, 32'h13579BDF);
        rd(A_POLY, v); check("R9 poly untouched", v, P_STD);
        rd(8'h04, v); check("R9 unmapped read 04", v, 32'h0);
        rd(8'h1C, v); check("R9 unmapped read 1C", v, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset;
        t_regmap;
        t_reload;
        t_word;
        t_byte;
        t_modes;
        t_outrev;
        t_vector;
        t_ignore;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule